// File: doc/BRIEF.md
# Address-Mark Wakeup Serial Receiver

This block receives 8-bit asynchronous serial characters and can be put into a receiver-sleep state. The serial line passes through a two-stage synchronizer. The bit timing runs on an external 16x oversampling tick enable. Software sets sleep with a one-cycle write strobe. While asleep, the receiver still frames every character, but it throws away any character whose most significant data bit is 0. A character whose most significant bit is 1 is an address mark. It ends sleep as soon as that bit is sampled, which is before any stop bit arrives. That same character is then delivered as received data.

Received characters leave on a valid/ready stream. `rx_valid` serves as the receive-full flag. A byte is consumed on a cycle where `rx_valid` and `rx_ready` are both high. While `rx_valid` is high and `rx_ready` is low, the byte and its framing-error bit are held unchanged. A character that completes during such a stall is dropped, and the held byte is kept. The `two_stop` pin selects one or two stop bits. Idle line time has no effect on the sleep state.

Top module: `amwk_rx`

## Requirements
- R1: After reset `rx_valid` is 0 and `sleeping` is 0.
- R2: A character is a low start bit, then 8 data bits with the least significant bit first, then the stop bit(s). Each bit lasts 16 `os_tick` pulses. A start is accepted only if the line is still low 8 ticks after the falling edge, so a shorter low pulse produces no byte.
- R3: While awake, every framed character is presented on `rx_data`, with either value of bit 7.
- R4: A one-cycle `sleep_wr` pulse sets `sleeping` to 1. While asleep, characters with bit 7 = 0 produce no output.
- R5: While asleep, an idle (high) line of any length leaves `sleeping` at 1.
- R6: While asleep, a character with bit 7 = 1 clears `sleeping` before its stop bit is sampled, and that character is delivered.
- R7: With `two_stop` = 1, two stop bits are expected, and R6 wakeup behaves the same way.
- R8: If `sleep_wr` coincides with the cycle in which an address mark is sampled, the wakeup wins and `sleeping` ends at 0.
- R9: If any expected stop bit samples low, `rx_ferr` = 1 comes with the byte, and the byte is still stored.
- R10: While `rx_valid` = 1 and `rx_ready` = 0, `rx_data` and `rx_ferr` hold. A character that completes in that time is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | 16x oversampling enable |
| rxd | input | 1 | Asynchronous serial input, idle high |
| sleep_wr | input | 1 | Software strobe that sets sleep |
| two_stop | input | 1 | 1 = two stop bits |
| rx_valid | output | 1 | Received byte available (receive-full flag) |
| rx_ready | input | 1 | Consumer accepts the byte |
| rx_data | output | 8 | Received byte |
| rx_ferr | output | 1 | Framing error for the byte on `rx_data` |
| sleeping | output | 1 | Current receiver-sleep state |

## Verification
A sleep flag stuck high or cleared too late shows up at the ports as a missing address byte. The bench also reads `sleeping` partway through the first stop bit, so late clearing is caught within one bit time of the mark. Bad bit timing or shift order shows up as a wrong `rx_data` value on the very next delivered byte. A wrong priority between the write strobe and the wakeup leaves `sleeping` high at that mid-stop sample. A broken stall path shows up as changed `rx_data` while `rx_ready` is low.

// File: rtl/amwk_pkg.sv
package amwk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/amwk_sync.sv
module amwk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/amwk_frame.sv
module amwk_frame
  import amwk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              two_stop,
  output logic              msb_stb,
  output logic              msb_val,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              ferr
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DATA_W);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [IW-1:0] TOP  = IW'(DATA_W - 1);

  rx_state_e         st;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] shreg;
  logic              more_stop;
  logic              ferr_q;
  logic              at_bit;

  assign at_bit = tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      idx       <= '0;
      shreg     <= '0;
      more_stop <= 1'b0;
      ferr_q    <= 1'b0;
    end else if (tick) begin
      unique case (st)
        ST_IDLE: begin
          if (!line) begin
            st  <= ST_START;
            cnt <= '0;
          end
        end
        ST_START: begin
          if (cnt == MID) begin
            cnt    <= '0;
            idx    <= '0;
            ferr_q <= 1'b0;
            st     <= line ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            shreg <= {line, shreg[DATA_W-1:1]};
            if (idx == TOP) begin
              st        <= ST_STOP;
              more_stop <= two_stop;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt == LAST) begin
            cnt    <= '0;
            ferr_q <= ferr_q | ~line;
            if (more_stop) more_stop <= 1'b0;
            else           st        <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign msb_stb = at_bit && (st == ST_DATA) && (idx == TOP);
  assign msb_val = line;
  assign done    = at_bit && (st == ST_STOP) && !more_stop;
  assign data    = shreg;
  assign ferr    = ferr_q | ~line;
endmodule

// File: rtl/amwk_sleep.sv
module amwk_sleep (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_wr,
  input  logic msb_stb,
  input  logic msb_val,
  input  logic done,
  output logic addr_wake,
  output logic deliver,
  output logic sleeping
);
  logic sleep_q;

  assign addr_wake = msb_stb && msb_val && sleep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sleep_q <= 1'b0;
    else if (addr_wake) sleep_q <= 1'b0;
    else if (sleep_wr)  sleep_q <= 1'b1;
  end

  assign deliver  = done && !sleep_q;
  assign sleeping = sleep_q;
endmodule

// File: rtl/amwk_hold.sv
module amwk_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_ferr,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_ferr
);
  logic take;
  assign take = load && (!valid || ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      out_data <= '0;
      out_ferr <= 1'b0;
    end else if (take) begin
      valid    <= 1'b1;
      out_data <= in_data;
      out_ferr <= in_ferr;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/amwk_rx.sv
module amwk_rx #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              sleep_wr,
  input  logic              two_stop,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ferr,
  output logic              sleeping
);
  logic              line_s;
  logic              msb_stb, msb_val, done, ferr, addr_wake, deliver;
  logic [DATA_W-1:0] data;

  amwk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(rxd), .d_out(line_s)
  );

  amwk_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line_s),
    .two_stop(two_stop), .msb_stb(msb_stb), .msb_val(msb_val),
    .done(done), .data(data), .ferr(ferr)
  );

  amwk_sleep u_sleep (
    .clk(clk), .rst_n(rst_n), .sleep_wr(sleep_wr), .msb_stb(msb_stb),
    .msb_val(msb_val), .done(done), .addr_wake(addr_wake),
    .deliver(deliver), .sleeping(sleeping)
  );

  amwk_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(deliver), .in_data(data),
    .in_ferr(ferr), .ready(rx_ready), .valid(rx_valid),
    .out_data(rx_data), .out_ferr(rx_ferr)
  );
endmodule

// File: rtl/amwk_rx_chk.sv
module amwk_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_wr,
  input logic              sleeping,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ferr,
  input logic              addr_wake
);
  p_wake_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wake |=> !sleeping);

  p_wr_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_wr && !addr_wake) |=> sleeping);

  p_wake_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_wr && addr_wake) |=> !sleeping);

  p_idle_keeps_sleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && !addr_wake) |=> sleeping);

  p_no_out_asleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> !$past(sleeping));

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid && $stable(rx_data) && $stable(rx_ferr));
endmodule

bind amwk_rx amwk_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_wr(sleep_wr), .sleeping(sleeping),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .rx_ferr(rx_ferr), .addr_wake(addr_wake)
);

// File: tb/test_amwk_rx.sv
module test_amwk_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b1;
  logic       rxd = 1'b1;
  logic       sleep_wr = 1'b0;
  logic       two_stop = 1'b0;
  logic       rx_ready = 1'b1;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_ferr;
  logic       sleeping;

  int checks = 0;
  int errors = 0;
  int div = 1;
  int tcnt = 0;
  bit mdl_sleep = 1'b0;
  logic [8:0] expq[$];

  always #2 clk = ~clk;

  amwk_rx i_amwk_rx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .sleep_wr(sleep_wr), .two_stop(two_stop), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_ferr(rx_ferr),
    .sleeping(sleeping)
  );

  always @(negedge clk) begin
    tcnt    <= (tcnt + 1 >= div) ? 0 : tcnt + 1;
    os_tick <= (tcnt == 0);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop on every handshake
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (expq.size() == 0) begin
        check("R3 unexpected byte", {23'd0, rx_ferr, rx_data}, 32'h1ff);
      end else begin
        logic [8:0] e;
        e = expq.pop_front();
        check("R3/R9 byte", {23'd0, rx_ferr, rx_data}, {23'd0, e});
      end
    end
  end

  // driver: one character, cycle by cycle on falling edges
  task automatic send(input logic [7:0] d, input int nst, input logic s1,
                      input logic s2, input int wr_at, input int chk_at,
                      input logic chk_val, input bit push_en, input string req);
    int bt = 16 * div;
    int total = bt * (9 + nst);
    bit keep = (!mdl_sleep || d[7]) && push_en;
    if (keep) expq.push_back({~(s1 & (nst == 1 ? 1'b1 : s2)), d});
    if (d[7]) mdl_sleep = 1'b0;
    for (int c = 0; c < total; c++) begin
      int b = c / bt;
      @(negedge clk);
      if (b == 0)      rxd = 1'b0;
      else if (b <= 8) rxd = d[b-1];
      else if (b == 9) rxd = s1;
      else             rxd = s2;
      sleep_wr = (c == wr_at);
      if (c == chk_at) check(req, {31'd0, sleeping}, {31'd0, chk_val});
    end
    @(negedge clk);
    rxd = 1'b1;
    sleep_wr = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic go_sleep();
    @(negedge clk); sleep_wr = 1'b1;
    @(negedge clk); sleep_wr = 1'b0;
    mdl_sleep = 1'b1;
    check("R4 sleep set", {31'd0, sleeping}, 32'd1);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", {31'd0, rx_valid}, 32'd0);
    check("R1 sleeping", {31'd0, sleeping}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3 awake reception, several patterns
    send(8'h35, 1, 1, 1, -1, -1, 0, 1, "");
    send(8'h5A, 1, 1, 1, -1, -1, 0, 1, "");
    send(8'h00, 1, 1, 1, -1, -1, 0, 1, "");
    send(8'hC3, 1, 1, 1, -1, -1, 0, 1, "");
    // R7 two stop bits awake
    two_stop = 1'b1;
    send(8'h7E, 2, 1, 1, -1, -1, 0, 1, "");
    // R9 second stop low
    send(8'h44, 2, 1, 0, -1, -1, 0, 1, "");
    two_stop = 1'b0;
    // R9 single stop low
    send(8'h21, 1, 0, 1, -1, -1, 0, 1, "");
    repeat (40) @(negedge clk);

    // R2 short low pulse is not a start
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (60) @(negedge clk);
    check("R2 glitch no byte", {31'd0, rx_valid}, 32'd0);

    // R4 discard while asleep, R5 idle, R6 wake
    go_sleep();
    send(8'h12, 1, 1, 1, -1, -1, 0, 1, "");
    send(8'h34, 1, 1, 1, -1, 100, 1, 1, "R4 still asleep");
    repeat (400) @(negedge clk);
    check("R5 idle keeps sleep", {31'd0, sleeping}, 32'd1);
    check("R4 no output", {31'd0, rx_valid}, 32'd0);
    send(8'h81, 1, 1, 1, -1, 150, 0, 1, "R6 awake before stop");

    // R7 wake with two stop bits
    two_stop = 1'b1;
    go_sleep();
    send(8'h05, 2, 1, 1, -1, -1, 0, 1, "");
    send(8'hA5, 2, 1, 1, -1, 150, 0, 1, "R7 awake before stop");
    two_stop = 1'b0;

    // R8 write strobe in the same cycle as the mark sample
    go_sleep();
    send(8'h90, 1, 1, 1, 138, 150, 0, 1, "R8 wake wins");
    check("R8 final", {31'd0, sleeping}, 32'd0);

    // R10 back-pressure
    rx_ready = 1'b0;
    send(8'h66, 1, 1, 1, -1, -1, 0, 1, "");
    check("R10 valid held", {31'd0, rx_valid}, 32'd1);
    check("R10 data", {24'd0, rx_data}, 32'h66);
    send(8'h77, 1, 1, 1, -1, -1, 0, 0, "");
    check("R10 data kept", {24'd0, rx_data}, 32'h66);
    @(negedge clk); rx_ready = 1'b1;
    repeat (5) @(negedge clk);

    // R2 slower tick enable
    div = 2;
    repeat (4) @(negedge clk);
    send(8'h3C, 1, 1, 1, -1, -1, 0, 1, "");
    div = 1;
    repeat (20) @(negedge clk);

    check("R3 all bytes seen", expq.size(), 32'd0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule